// File: doc/BRIEF.md
# One-Hot Coin-Accumulating Vending Controller

This block is the sequencing core of a single-item dispenser that charges 15 cents. A coin sensor reports each accepted coin as a one-cycle pulse on one of two inputs: one for a 5-cent coin and one for a 10-cent coin. The controller keeps the credit collected so far. When the credit reaches the price, it raises a release output. It never returns change, so any overpayment is kept.

The credit is held in a one-hot register with one flip-flop per reachable amount: 0, 5, 10 and 15 cents. Each next-state bit is built directly from the arcs of the state diagram, with one product term per incoming arc. A small qualifier stage in front of the register turns the raw sensor pulses into advance strobes. The qualifier treats a cycle with both coins reported as a cycle with no coin, so the behaviour for that input is fixed. The release output is a Moore output, driven straight from the 15-cent flip-flop. The 15-cent state is kept until a synchronous reset clears it.

Top module: `vendOneHotCtrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) puts the controller in the 0-cent state, with state vector 4'b0001 and `openOut` low. From that state, exactly three 5-cent coins are needed to raise `openOut`.
- R2: In a cycle with neither coin input high, the credit state does not change.
- R3: A 5-cent pulse (`nickelIn`=1, `dimeIn`=0) moves the credit up one state: 0 to 5, 5 to 10, 10 to 15.
- R4: A 10-cent pulse (`dimeIn`=1, `nickelIn`=0) moves the credit up two states: 0 to 10, 5 to 15.
- R5: In the 10-cent state, either coin moves the controller to the 15-cent state. The excess 5 cents is absorbed without any other effect.
- R6: `openOut` is high only in the 15-cent state. It changes only after a rising clock edge, one edge after the coin that completes the price, and it never depends combinationally on the coin inputs.
- R7: Once in the 15-cent state, the controller stays there whatever coins arrive, until reset.
- R8: A cycle with both `nickelIn` and `dimeIn` high leaves the credit state unchanged, exactly as a cycle with no coin does.
- R9: At every clock edge outside reset, the 4-bit state vector (bit 0 = 0 cents, bit 1 = 5, bit 2 = 10, bit 3 = 15) has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickelIn | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| dimeIn | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| openOut | output | 1 | Release command, high in the 15-cent state |

## Verification
The bench targets these corner cases:
- **Overpayment from 10 cents with a dime.** A design that lacks that arc would stay stuck at 10 cents, or would lose the state bit entirely.
- **Coins after the price is reached.** A design that does not make the 15-cent state sticky would drop `openOut` or wrap back to 0.
- **Both coin inputs high in one cycle.** A design that treats this as a dime, a nickel, or both added together would open one or two coins early.
- **Reset in the middle of a purchase.** A design that clears the register to the wrong state would open on the wrong coin count.

Random coin streams are compared cycle by cycle against a saturating credit model. They cover hold cycles between coins of every length.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int COIN_UNIT_CENTS = 5;
  localparam int PRICE_CENTS     = 15;
  localparam int PRICE_STEPS     = PRICE_CENTS / COIN_UNIT_CENTS;

  // Advance strobes handed from the coin qualifier to the credit register
  typedef struct packed {
    logic addOne;   // one coin unit
    logic addTwo;   // two coin units
  } coinStrobe_t;
endpackage

// File: rtl/vendCoinQual.sv
module vendCoinQual
  import vend_pkg::*;
(
  input  logic        nickelIn,
  input  logic        dimeIn,
  output coinStrobe_t strobe
);
  // Both sensors at once is resolved as no coin, so the state holds
  always_comb begin
    strobe.addOne = nickelIn & ~dimeIn;
    strobe.addTwo = dimeIn & ~nickelIn;
  end
endmodule

// File: rtl/vendCreditFsm.sv
module vendCreditFsm
  import vend_pkg::*;
#(
  parameter int STEPS = PRICE_STEPS
) (
  input  logic              clk,
  input  logic              rst,
  input  coinStrobe_t       strobe,
  output logic [STEPS:0]    stateVec
);
  localparam int LAST = STEPS;
  localparam logic [STEPS:0] RESET_VEC = {{STEPS{1'b0}}, 1'b1};

  logic [STEPS:0] nextVec;
  logic           advance;

  assign advance = strobe.addOne | strobe.addTwo;

  // One product term per incoming arc of the state diagram
  genvar i;
  generate
    for (i = 0; i <= LAST; i++) begin : g_arc
      if (i == 0) begin : g_zero
        assign nextVec[i] = stateVec[i] & ~advance;
      end else if (i == 1) begin : g_first
        assign nextVec[i] = (stateVec[i] & ~advance)
                          | (stateVec[i-1] & strobe.addOne);
      end else if (i < LAST) begin : g_mid
        assign nextVec[i] = (stateVec[i] & ~advance)
                          | (stateVec[i-1] & strobe.addOne)
                          | (stateVec[i-2] & strobe.addTwo);
      end else begin : g_final
        // sticky final state; from one below, any coin arrives here
        assign nextVec[i] = stateVec[i]
                          | (stateVec[i-1] & advance)
                          | (stateVec[i-2] & strobe.addTwo);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stateVec <= RESET_VEC;
    else     stateVec <= nextVec;
  end

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(stateVec) == 1);                                  // R9

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> stateVec == RESET_VEC);                       // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(stateVec));                             // R2

  AST_FINAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    stateVec[LAST] |=> stateVec[LAST]);                          // R7

  AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.addOne && !stateVec[LAST]) |=> stateVec == ($past(stateVec) << 1)); // R3
endmodule

// File: rtl/vendOneHotCtrl.sv
module vendOneHotCtrl
  import vend_pkg::*;
#(
  parameter int STEPS = PRICE_STEPS
) (
  input  logic clk,
  input  logic rst,
  input  logic nickelIn,
  input  logic dimeIn,
  output logic openOut
);
  coinStrobe_t    strobe;
  logic [STEPS:0] creditVec;

  vendCoinQual u_qual (
    .nickelIn (nickelIn),
    .dimeIn   (dimeIn),
    .strobe   (strobe)
  );

  vendCreditFsm #(.STEPS(STEPS)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .stateVec (creditVec)
  );

  // Moore output taken straight from the final-state flip-flop
  assign openOut = creditVec[STEPS];

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (nickelIn && dimeIn) |=> $stable(creditVec));                // R8

  AST_OPEN_AFTER_COIN: assert property (@(posedge clk) disable iff (rst)
    $rose(openOut) |-> $past(nickelIn ^ dimeIn));                // R6

  AST_OVERPAY: assert property (@(posedge clk) disable iff (rst)
    (creditVec[STEPS-1] && dimeIn && !nickelIn) |=> openOut);    // R5
endmodule

// File: tb/vendOneHotCtrl_tb.sv
module vendOneHotCtrl_tb;
  logic clk = 0;
  logic rst = 1;
  logic nickelIn = 0;
  logic dimeIn = 0;
  logic openOut;

  int checks = 0;
  int fails = 0;
  int credit = 0;   // model credit in 5-cent units, saturating at 3
  bit done = 0;

  always #5 clk = ~clk;

  vendOneHotCtrl u_dut (
    .clk(clk), .rst(rst), .nickelIn(nickelIn), .dimeIn(dimeIn), .openOut(openOut)
  );

  function automatic int nextCredit(int c, bit n, bit d);
    int r;
    if (c >= 3) return 3;
    r = c;
    if (n && !d) r = c + 1;
    else if (d && !n) r = c + 2;
    if (r > 3) r = 3;
    return r;
  endfunction

  function automatic bit expOpen(int c);
    return c >= 3;
  endfunction

  task automatic check(string req);
    checks++;
    if (openOut !== expOpen(credit)) begin
      fails++;
      $display("FAIL %s: openOut=%b expected=%b (credit=%0d)", req, openOut, expOpen(credit), credit);
    end
  endtask

  // drive on negedge, sample 1 ns after the following posedge
  task automatic step(bit n, bit d, bit r, string req);
    @(negedge clk);
    nickelIn = n; dimeIn = d; rst = r;
    @(posedge clk);
    if (r) credit = 0;
    else credit = nextCredit(credit, n, d);
    #1;
    check(req);
  endtask

  initial begin
    int pick;
    int unused;
    unused = $urandom(32'h15C0_FFEE);
    step(0, 0, 1, "R1");
    step(0, 0, 1, "R1");
    // R1: three nickels from reset
    step(1, 0, 0, "R3"); step(0, 0, 0, "R2");
    step(1, 0, 0, "R3"); step(0, 0, 0, "R2");
    step(1, 0, 0, "R1");
    // R7: sticky final state
    step(1, 0, 0, "R7"); step(0, 1, 0, "R7"); step(1, 1, 0, "R7"); step(0, 0, 0, "R7");
    // R4 / R5: dime then dime overpays
    step(0, 0, 1, "R1");
    step(0, 1, 0, "R4"); step(0, 0, 0, "R2"); step(0, 1, 0, "R5");
    // R4: nickel then dime
    step(0, 0, 1, "R1");
    step(1, 0, 0, "R3"); step(0, 1, 0, "R4");
    // R5: two nickels then dime
    step(0, 0, 1, "R1");
    step(1, 0, 0, "R3"); step(1, 0, 0, "R3"); step(0, 1, 0, "R5");
    // R8: both coins ignored at every credit level
    step(0, 0, 1, "R1");
    step(1, 1, 0, "R8"); step(1, 0, 0, "R3"); step(1, 1, 0, "R8");
    step(1, 1, 0, "R8"); step(1, 0, 0, "R3"); step(1, 1, 0, "R8");
    step(1, 0, 0, "R6");
    // R1: reset mid-purchase
    step(0, 0, 1, "R1");
    step(0, 1, 0, "R4"); step(0, 0, 1, "R1");
    step(1, 0, 0, "R3"); step(1, 0, 0, "R3"); step(0, 0, 0, "R6"); step(1, 0, 0, "R6");
    // random streams
    for (int k = 0; k < 3000; k++) begin
      pick = $urandom_range(0, 15);
      if (pick == 0) step(0, 0, 1, "R1");
      else if (pick < 6) step(0, 0, 0, "R2");
      else if (pick < 10) step(1, 0, 0, "R3");
      else if (pick < 14) step(0, 1, 0, "R4");
      else step(1, 1, 0, "R8");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule